// File: doc/BRIEF.md
# Sign-flip SAR conversion controller

This block is the digital sequencer of a differential successive-approximation converter whose resolution is chosen at run time, from one to eight bits. Each conversion begins with a purge of the DAC and a sign decision taken against a zero DAC code. A non-negative input keeps the DAC in its normal polarity and the magnitude is searched directly. A negative input sets the flip control, so the DAC tracks the complemented residue. At the end the controller inverts those tracked bits, which gives an offset-binary result without a second search direction.

Two sampling banks are used in turn: one captures the next input while the other is converted. Every accepted start hands the sampling bank over to conversion and moves sampling to the other bank. Comparator decisions arrive with a strobe, and the controller only advances on a strobe. When the last enabled bit is known, the result is written to a data register with a one-cycle valid pulse, the bank it came from and a spike flag. The spike flag compares the tracked magnitude with a threshold input.

Top module: `sfsar_ctrl`

## Requirements
- R1: After reset, valid_o, spike_o, purge_o, flip_o, samp_bank_o, res_bank_o, dac_o and data_o are all zero.
- R2: A start accepted while idle makes purge_o high for exactly the next cycle, with dac_o zero and flip_o low. The first decision that follows is the sign decision.
- R3: With res_i equal to r, the conversion takes N = r+1 decisions. data_o[7] is the sign (1 for a non-negative input) and data_o[6:0] holds the N-1 magnitude bits MSB first. Lower bits are zero, so data_o equals the top N bits of the input offset by +128, followed by zeros.
- R4: A sign decision of 0 raises flip_o, which stays high until the next accepted start. The magnitude is then searched on the complemented residue and the output magnitude bits are the inverse of the tracked bits.
- R5: Decisions are taken only in cycles where strobe_i is high. Without a strobe, dac_o and flip_o hold and the result is the same as with a continuous strobe.
- R6: valid_o is a single-cycle pulse that follows the last enabled decision.
- R7: samp_bank_o toggles on each accepted start. res_bank_o, sampled with valid_o, equals the value samp_bank_o had when that start was accepted.
- R8: res_i is captured when start is accepted. A later change does not alter the conversion in progress.
- R9: start_i is ignored while a conversion is in progress: there is no restart and no bank toggle.
- R10: spike_o is high only together with valid_o, and only when the tracked magnitude code is at or above thr_i. The tracked magnitude code is the input for a non-negative sign and -input-1 for a negative sign, truncated to N-1 bits.
- R11: With strobe_i held high, valid_o is seen after the (N+1)th rising edge following the edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a conversion when idle |
| strobe_i | input | 1 | Comparator decision is valid this cycle |
| cmp_i | input | 1 | Comparator decision, 1 when the input is at or above the DAC level |
| res_i | input | 3 | Resolution setting, N = res_i + 1 bits |
| thr_i | input | 7 | Spike threshold on the tracked magnitude code |
| dac_o | output | 7 | Magnitude trial code driving the DAC switches |
| flip_o | output | 1 | DAC polarity flip |
| purge_o | output | 1 | DAC purge before the sign decision |
| samp_bank_o | output | 1 | Bank currently sampling |
| data_o | output | 8 | Result register, sign then magnitude, zero-filled |
| valid_o | output | 1 | One-cycle result valid pulse |
| res_bank_o | output | 1 | Bank the current result was converted from |
| spike_o | output | 1 | Result magnitude at or above threshold |

## Verification
The hardest case to reach from the ports is a negative input under flipped tracking at every resolution, with gaps in the strobe and with start or res_i toggled in the middle of a search. The bench models the analog side as an ideal comparator. It reads the converting bank's signed sample together with dac_o and flip_o, so each trial is answered as the capacitor array would answer it. Start pulses and resolution changes are placed on counted cycles inside the search, and a strobe pattern with gaps stretches the decision sequence.

// File: rtl/sfsar_pkg.sv
package sfsar_pkg;

    localparam int unsigned CODE_W = 8;
    localparam int unsigned MAG_W  = CODE_W - 1;
    localparam int unsigned RES_W  = $clog2(CODE_W);
    localparam int unsigned POS_W  = $clog2(MAG_W);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PURGE,
        PH_SIGN,
        PH_MAG
    } phase_e;

    typedef logic [MAG_W-1:0] mag_t;

    typedef struct packed {
        logic sign;
        mag_t mag;
    } code_t;

    // Mask of the top nmag magnitude positions.
    function automatic mag_t keep_mask(input logic [RES_W-1:0] nmag);
        mag_t m;
        m = '0;
        for (int i = 0; i < int'(MAG_W); i++) begin
            if (i < int'(nmag)) begin
                m[MAG_W-1-i] = 1'b1;
            end
        end
        return m;
    endfunction

    // Lowest magnitude bit position that is searched for nmag bits.
    function automatic logic [POS_W-1:0] low_pos(input logic [RES_W-1:0] nmag);
        return POS_W'(int'(MAG_W) - int'(nmag));
    endfunction

    // Tracked code to true code: a negative sign means the bits were tracked inverted.
    function automatic code_t to_output(input code_t trk, input mag_t mask);
        code_t o;
        o.sign = trk.sign;
        o.mag  = (trk.sign ? trk.mag : ~trk.mag) & mask;
        return o;
    endfunction

endpackage

// File: rtl/sfsar_seq.sv
module sfsar_seq
    import sfsar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             strobe_i,
    input  logic [RES_W-1:0] res_i,
    output phase_e           phase_o,
    output logic             accept_o,
    output logic             sign_dec_o,
    output logic             mag_dec_o,
    output logic             last_o,
    output logic             finish_o,
    output logic [POS_W-1:0] pos_o,
    output logic [RES_W-1:0] nmag_o
);

    phase_e           phase_q;
    logic [POS_W-1:0] pos_q;
    logic [RES_W-1:0] nmag_q;

    always_comb begin
        accept_o   = (phase_q == PH_IDLE) && start_i;
        sign_dec_o = (phase_q == PH_SIGN) && strobe_i;
        mag_dec_o  = (phase_q == PH_MAG) && strobe_i;
        last_o     = (pos_q == low_pos(nmag_q));
        finish_o   = (sign_dec_o && (nmag_q == '0)) || (mag_dec_o && last_o);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pos_q   <= '0;
            nmag_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_PURGE;
                        nmag_q  <= res_i;
                    end
                end
                PH_PURGE: begin
                    phase_q <= PH_SIGN;
                end
                PH_SIGN: begin
                    if (strobe_i) begin
                        if (nmag_q == '0) begin
                            phase_q <= PH_IDLE;
                        end else begin
                            phase_q <= PH_MAG;
                            pos_q   <= POS_W'(MAG_W - 1);
                        end
                    end
                end
                PH_MAG: begin
                    if (strobe_i) begin
                        if (last_o) begin
                            phase_q <= PH_IDLE;
                        end else begin
                            pos_q <= pos_q - 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign pos_o   = pos_q;
    assign nmag_o  = nmag_q;

endmodule

// File: rtl/sfsar_trial.sv
module sfsar_trial
    import sfsar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             sign_dec_i,
    input  logic             mag_dec_i,
    input  logic             last_i,
    input  logic             cmp_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [RES_W-1:0] nmag_i,
    output mag_t             dac_o,
    output logic             flip_o,
    output code_t            final_o
);

    code_t trk_q;
    logic  flip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q  <= '0;
            flip_q <= 1'b0;
        end else if (accept_i) begin
            trk_q  <= '0;
            flip_q <= 1'b0;
        end else if (sign_dec_i) begin
            trk_q.sign <= cmp_i;
            flip_q     <= ~cmp_i;
            if (nmag_i != '0) begin
                trk_q.mag[MAG_W-1] <= 1'b1;
            end
        end else if (mag_dec_i) begin
            trk_q.mag[pos_i] <= cmp_i;
            if (!last_i) begin
                trk_q.mag[pos_i - 1'b1] <= 1'b1;
            end
        end
    end

    // Tracked code including the decision being taken this cycle.
    always_comb begin
        final_o = trk_q;
        if (sign_dec_i) begin
            final_o.sign = cmp_i;
        end
        if (mag_dec_i) begin
            final_o.mag[pos_i] = cmp_i;
        end
    end

    assign dac_o  = trk_q.mag;
    assign flip_o = flip_q;

endmodule

// File: rtl/sfsar_result.sv
module sfsar_result
    import sfsar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              finish_i,
    input  code_t             final_i,
    input  logic [RES_W-1:0]  nmag_i,
    input  mag_t              thr_i,
    output logic [CODE_W-1:0] data_o,
    output logic              valid_o,
    output logic              spike_o,
    output logic              res_bank_o,
    output logic              samp_bank_o
);

    code_t data_q;
    logic  conv_bank_q;
    logic  samp_bank_q;
    logic  valid_q;
    logic  spike_q;
    logic  res_bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q      <= '0;
            valid_q     <= 1'b0;
            spike_q     <= 1'b0;
            res_bank_q  <= 1'b0;
            conv_bank_q <= 1'b0;
            samp_bank_q <= 1'b0;
        end else begin
            valid_q <= finish_i;
            spike_q <= finish_i && (final_i.mag >= thr_i);
            if (finish_i) begin
                data_q     <= to_output(final_i, keep_mask(nmag_i));
                res_bank_q <= conv_bank_q;
            end
            if (accept_i) begin
                conv_bank_q <= samp_bank_q;
                samp_bank_q <= ~samp_bank_q;
            end
        end
    end

    assign data_o      = data_q;
    assign valid_o     = valid_q;
    assign spike_o     = spike_q;
    assign res_bank_o  = res_bank_q;
    assign samp_bank_o = samp_bank_q;

endmodule

// File: rtl/sfsar_ctrl.sv
module sfsar_ctrl
    import sfsar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              strobe_i,
    input  logic              cmp_i,
    input  logic [RES_W-1:0]  res_i,
    input  logic [MAG_W-1:0]  thr_i,
    output logic [MAG_W-1:0]  dac_o,
    output logic              flip_o,
    output logic              purge_o,
    output logic              samp_bank_o,
    output logic [CODE_W-1:0] data_o,
    output logic              valid_o,
    output logic              res_bank_o,
    output logic              spike_o
);

    phase_e           phase;
    logic             accept;
    logic             sign_dec;
    logic             mag_dec;
    logic             last;
    logic             finish;
    logic [POS_W-1:0] pos;
    logic [RES_W-1:0] res_q;
    code_t            final_code;
    logic             busy;

    sfsar_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .strobe_i   (strobe_i),
        .res_i      (res_i),
        .phase_o    (phase),
        .accept_o   (accept),
        .sign_dec_o (sign_dec),
        .mag_dec_o  (mag_dec),
        .last_o     (last),
        .finish_o   (finish),
        .pos_o      (pos),
        .nmag_o     (res_q)
    );

    sfsar_trial u_trial (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .sign_dec_i (sign_dec),
        .mag_dec_i  (mag_dec),
        .last_i     (last),
        .cmp_i      (cmp_i),
        .pos_i      (pos),
        .nmag_i     (res_q),
        .dac_o      (dac_o),
        .flip_o     (flip_o),
        .final_o    (final_code)
    );

    sfsar_result u_result (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .finish_i    (finish),
        .final_i     (final_code),
        .nmag_i      (res_q),
        .thr_i       (thr_i),
        .data_o      (data_o),
        .valid_o     (valid_o),
        .spike_o     (spike_o),
        .res_bank_o  (res_bank_o),
        .samp_bank_o (samp_bank_o)
    );

    assign purge_o = (phase == PH_PURGE);
    assign busy    = (phase != PH_IDLE);

endmodule

// File: rtl/sfsar_ctrl_chk.sv
module sfsar_ctrl_chk
    import sfsar_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              strobe_i,
    input logic              busy,
    input logic [RES_W-1:0]  res_q,
    input logic [MAG_W-1:0]  dac_o,
    input logic              flip_o,
    input logic              purge_o,
    input logic              samp_bank_o,
    input logic [CODE_W-1:0] data_o,
    input logic              valid_o,
    input logic              spike_o
);

    a_r2_purge_one_cycle: assert property (@(posedge clk) disable iff (rst)
        purge_o |=> !purge_o);

    a_r2_purge_dac_clear: assert property (@(posedge clk) disable iff (rst)
        purge_o |-> (dac_o == '0 && !flip_o));

    a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        (busy && !purge_o && !strobe_i) |=> ($stable(dac_o) && $stable(flip_o)));

    a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    a_r7_bank_toggles: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_i) |=> (samp_bank_o != $past(samp_bank_o)));

    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i) |=> $stable(samp_bank_o));

    a_r8_res_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(res_q));

    a_r3_zero_fill: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ((data_o[MAG_W-1:0] & ~keep_mask(res_q)) == '0));

    a_r10_spike_with_valid: assert property (@(posedge clk) disable iff (rst)
        spike_o |-> valid_o);

endmodule

bind sfsar_ctrl sfsar_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .strobe_i    (strobe_i),
    .busy        (busy),
    .res_q       (res_q),
    .dac_o       (dac_o),
    .flip_o      (flip_o),
    .purge_o     (purge_o),
    .samp_bank_o (samp_bank_o),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .spike_o     (spike_o)
);

// File: tb/sfsar_ctrl_test.sv
module sfsar_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       strobe_i = 1'b1;
    logic       cmp_i;
    logic [2:0] res_i = 3'd7;
    logic [6:0] thr_i = 7'd0;
    logic [6:0] dac_o;
    logic       flip_o;
    logic       purge_o;
    logic       samp_bank_o;
    logic [7:0] data_o;
    logic       valid_o;
    logic       res_bank_o;
    logic       spike_o;

    int errors = 0;
    int checks = 0;
    int samp [2] = '{0, 0};
    int cbank = 0;
    bit gap_mode = 1'b0;
    bit done = 1'b0;

    // Results captured by the conversion task.
    logic [7:0] got_data;
    bit got_bank, got_spike, got_purge, got_flip, got_single;
    int got_lat;

    always #10 clk = ~clk;

    // Ideal comparator acting on the converting bank's sample.
    int cur_s;
    assign cur_s = samp[cbank];
    assign cmp_i = flip_o ? ((-cur_s - 1) >= int'(dac_o)) : (cur_s >= int'(dac_o));

    sfsar_ctrl uut (
        .clk(clk), .rst(rst), .start_i(start_i), .strobe_i(strobe_i), .cmp_i(cmp_i),
        .res_i(res_i), .thr_i(thr_i), .dac_o(dac_o), .flip_o(flip_o), .purge_o(purge_o),
        .samp_bank_o(samp_bank_o), .data_o(data_o), .valid_o(valid_o),
        .res_bank_o(res_bank_o), .spike_o(spike_o)
    );

    // Strobe pattern with gaps when gap_mode is set.
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            k++;
            strobe_i = gap_mode ? ((k % 3) == 0) : 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int x, input int r);
        int n = r + 1;
        return ((x + 128) >> (8 - n)) << (8 - n);
    endfunction

    function automatic bit exp_spike(input int x, input int r, input int thr);
        int n = r + 1;
        int t = (x >= 0) ? x : -x - 1;
        return (((t >> (8 - n)) << (8 - n)) >= thr);
    endfunction

    // chg: change res_i after acceptance; extra: pulse start while busy.
    task automatic convert(input int x, input int r, input int thr, input bit chg, input bit extra);
        int cnt;
        @(negedge clk);
        samp[samp_bank_o] = x;
        cbank = int'(samp_bank_o);
        res_i = 3'(r);
        thr_i = 7'(thr);
        start_i = 1'b1;
        @(posedge clk);
        cnt = 1;
        @(negedge clk);
        start_i = 1'b0;
        got_purge = purge_o && (dac_o == 7'd0) && !flip_o;
        if (chg) res_i = ~3'(r);
        while (!valid_o && cnt < 200) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (extra && cnt == 2) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        got_lat = cnt;
        got_data = data_o;
        got_bank = res_bank_o;
        got_spike = spike_o;
        got_flip = flip_o;
        @(negedge clk);
        got_single = !valid_o;
    endtask

    localparam int NV = 16;
    localparam int TAB [NV][3] = '{
        '{127, 7, 0}, '{-128, 7, 0}, '{0, 7, 1}, '{-1, 7, 0},
        '{100, 7, 64}, '{-100, 7, 100}, '{37, 3, 32}, '{-37, 3, 40},
        '{5, 0, 0}, '{-5, 0, 1}, '{64, 1, 64}, '{-65, 1, 64},
        '{90, 4, 127}, '{-90, 5, 80}, '{13, 6, 12}, '{-13, 2, 0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit sb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(valid_o == 0 && spike_o == 0 && purge_o == 0 && flip_o == 0, "R1 flags", 1, 0);
        check(samp_bank_o == 0 && res_bank_o == 0, "R1 banks", int'(samp_bank_o), 0);
        check(data_o == 0 && dac_o == 0, "R1 data", int'(data_o), 0);

        for (int i = 0; i < NV; i++) begin
            int x = TAB[i][0];
            int r = TAB[i][1];
            int t = TAB[i][2];
            sb = samp_bank_o;
            convert(x, r, t, 1'b0, 1'b0);
            check(got_data == 8'(exp_code(x, r)), "R3 code", int'(got_data), exp_code(x, r));
            check(got_flip == (x < 0), "R4 flip", int'(got_flip), int'(x < 0));
            check(got_purge, "R2 purge", int'(got_purge), 1);
            check(got_single, "R6 single valid", int'(got_single), 1);
            check(got_bank == sb && samp_bank_o == !sb, "R7 bank", int'(got_bank), int'(sb));
            check(got_spike == exp_spike(x, r, t), "R10 spike", int'(got_spike), int'(exp_spike(x, r, t)));
            check(got_lat == r + 3, "R11 latency", got_lat, r + 3);
        end

        // R5: strobe with gaps gives the same code
        gap_mode = 1'b1;
        convert(-77, 7, 0, 1'b0, 1'b0);
        check(got_data == 8'(exp_code(-77, 7)), "R5 gapped strobe", int'(got_data), exp_code(-77, 7));
        convert(58, 4, 0, 1'b0, 1'b0);
        check(got_data == 8'(exp_code(58, 4)), "R5 gapped strobe", int'(got_data), exp_code(58, 4));
        gap_mode = 1'b0;
        @(negedge clk);

        // R8: resolution change mid-conversion ignored
        convert(45, 7, 0, 1'b1, 1'b0);
        check(got_data == 8'(exp_code(45, 7)), "R8 res held", int'(got_data), exp_code(45, 7));
        convert(-99, 2, 0, 1'b1, 1'b0);
        check(got_data == 8'(exp_code(-99, 2)), "R8 res held", int'(got_data), exp_code(-99, 2));

        // R9: start while busy ignored
        sb = samp_bank_o;
        convert(-20, 7, 0, 1'b0, 1'b1);
        check(got_data == 8'(exp_code(-20, 7)), "R9 busy start code", int'(got_data), exp_code(-20, 7));
        check(got_lat == 10, "R9 no restart", got_lat, 10);
        check(samp_bank_o == !sb, "R9 one toggle", int'(samp_bank_o), int'(!sb));
        check(!purge_o && !valid_o, "R9 idle after", int'(purge_o), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule